// File: doc/BRIEF.md
# SPI Flash Erase and Page-Program Sequencer

This block is the master-side sequencer that sits on top of an SPI byte engine and runs complete erase and program operations on a serial NOR flash. A single command selects sector erase, whole-chip erase or program. The block then produces every chip-select frame itself. It sends a write-enable frame and polls the status register until the device is idle with its write-enable latch set. It then sends the erase or page-program frame and polls again until the internal write finishes.

Program commands take their payload from a valid/ready byte stream. A request that runs past the end of a flash page is cut at each page boundary, and every piece gets its own write-enable, program and polling sequence. Each status poll has a retry cap. When a poll phase runs out of retries, the operation is abandoned with chip select high and the error output set.

The byte engine interface moves one byte at a time. A request is offered with valid/ready, and the engine returns one received byte for every byte it sends. Only one byte is outstanding at any moment. The write-data stream follows the usual rules: a byte moves on a cycle where `wdata_valid` and `wdata_ready` are both high. Once the source raises `wdata_valid`, it must hold the valid and the byte until that transfer. The block raises `wdata_ready` only in a cycle in which the engine accepts the same byte.

Top module: `nvs_flash_writer`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `byte_req_valid` is 0, `done` is 0, `err` is 0 and `cmd_ready` is 1.
- R2: Every erase operation, and every page piece of a program operation, starts with a frame that holds only the write-enable byte 0x06.
- R3: Between any two frames, `spi_cs_n` stays high for at least `GAP_CYCLES` clock cycles. Byte requests are only made while `spi_cs_n` is low.
- R4: A status poll is one frame of exactly two bytes, 0x05 then 0x00. The first received byte is discarded and the second is the status. Bit 0 is write-in-progress and bit 1 is the write-enable latch.
- R5: After write enable, polling repeats until a status shows bit 0 clear and bit 1 set. No erase or program opcode is sent before that.
- R6: Sector erase (`cmd_op`=0) is the frame 0xD8 followed by three address bytes, most significant first. Bulk erase (`cmd_op`=1) is the single-byte frame 0xC7.
- R7: Program (`cmd_op`=2) frames are 0x02, three address bytes, then the stream bytes in arrival order. There are never more than `PAGE_BYTES` data bytes in a frame, and received bytes are discarded.
- R8: A program request is split into pieces. The size of each piece is min(remaining length, `PAGE_BYTES` minus the address offset within its page). The next piece starts at the next page boundary.
- R9: After every erase or program frame, polling repeats until bit 0 of the status is clear. The block then starts the next piece or finishes.
- R10: If a poll phase would need more than `MAX_POLLS` polls, the block stops after the last failing poll. Chip select stays high, and `err` rises together with `done`. `err` holds until the next command is accepted, and then clears.
- R11: A program of length 0, or `cmd_op`=3, finishes with `done` and no frame.
- R12: The block takes exactly the requested number of stream bytes. A stream byte moves only while a program frame's data byte is accepted by the engine. A stalled engine request keeps its valid and byte.
- R13: `cmd_ready` is high only while idle, and a command is taken on `cmd_valid` && `cmd_ready`. `done` is a single-cycle pulse at the end of each command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 2 | 0 sector erase, 1 bulk erase, 2 program, 3 no operation |
| cmd_addr | input | 24 | Flash byte address |
| cmd_len | input | LEN_W | Program length in bytes |
| wdata_valid | input | 1 | Program stream byte available |
| wdata_ready | output | 1 | Program stream byte taken |
| wdata | input | 8 | Program stream byte |
| spi_cs_n | output | 1 | Flash chip select, active low |
| byte_req_valid | output | 1 | Byte offered to the SPI engine |
| byte_req_ready | input | 1 | Engine accepts the byte |
| byte_req_tx | output | 8 | Byte to shift out |
| byte_rsp_valid | input | 1 | Engine returns the byte shifted in |
| byte_rsp_rx | input | 8 | Byte shifted in |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Last command ended by poll timeout |

## Verification
The hardest cases to reach from the ports are the retry paths of the poll loop. These are a write-enable latch that appears only after several polls, a write that outlasts the poll cap, and a following command that must first wait for that leftover busy time. The bench therefore includes a flash responder whose write-in-progress time and latch delay are set per scenario, counted in polls. The timeout case is followed directly by a command that must recover. Page splitting is driven by a program request that starts 16 bytes before a boundary and spans three pages. Engine stalls are driven by a ready that toggles every cycle.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam int ADDR_W = 24;

  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_WREN, S_RDSR, S_STAT, S_OPC, S_ADDR, S_DATA, S_FIN
  } nvs_state_e;

  typedef enum logic [1:0] {
    OP_SECTOR = 2'd0,
    OP_BULK   = 2'd1,
    OP_PROG   = 2'd2,
    OP_NONE   = 2'd3
  } nvs_op_e;
endpackage

// File: rtl/nvs_gap_timer.sv
module nvs_gap_timer #(
  parameter int GAP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(GAP_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
    else          cnt_q <= '0;
  end

  assign expired = run && (cnt_q == CW'(GAP_CYCLES - 1));
endmodule

// File: rtl/nvs_poll_limit.sv
module nvs_poll_limit #(
  parameter int MAX_POLLS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (bump)  cnt_q <= cnt_q + 1'b1;
  end

  // the poll being evaluated now is the final one allowed
  assign last = (cnt_q == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/nvs_page_chunk.sv
module nvs_page_chunk #(
  parameter int PAGE_BYTES = 256,
  parameter int LEN_W      = 12
) (
  input  logic [$clog2(PAGE_BYTES)-1:0] addr_lo,
  input  logic [LEN_W-1:0]              remaining,
  output logic [LEN_W-1:0]              chunk
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int CW     = (LEN_W > PAGE_W + 1) ? LEN_W : PAGE_W + 1;

  logic [CW-1:0] room;
  logic [CW-1:0] rem_x;

  always_comb begin
    room  = CW'(PAGE_BYTES) - CW'(addr_lo);
    rem_x = CW'(remaining);
    if (rem_x < room) chunk = remaining;
    else              chunk = LEN_W'(room);
  end
endmodule

// File: rtl/nvs_flash_writer.sv
module nvs_flash_writer
  import nvs_pkg::*;
#(
  parameter int          GAP_CYCLES = 4,
  parameter int          MAX_POLLS  = 64,
  parameter int          PAGE_BYTES = 256,
  parameter int          LEN_W      = 12,
  parameter logic [7:0]  OPC_WREN   = 8'h06,
  parameter logic [7:0]  OPC_RDSR   = 8'h05,
  parameter logic [7:0]  OPC_SECTOR = 8'hD8,
  parameter logic [7:0]  OPC_BULK   = 8'hC7,
  parameter logic [7:0]  OPC_PROG   = 8'h02,
  parameter int          WIP_BIT    = 0,
  parameter int          WEL_BIT    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [23:0]       cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              wdata_valid,
  output logic              wdata_ready,
  input  logic [7:0]        wdata,
  output logic              spi_cs_n,
  output logic              byte_req_valid,
  input  logic              byte_req_ready,
  output logic [7:0]        byte_req_tx,
  input  logic              byte_rsp_valid,
  input  logic [7:0]        byte_rsp_rx,
  output logic              done,
  output logic              err
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  nvs_state_e           state_q, resume_q;
  nvs_op_e              op_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [LEN_W-1:0]     rem_q, left_q, chunk, rem_after;
  logic [1:0]           abyte_q;
  logic                 wait_q, post_q, err_q;
  logic                 in_frame, req_fire, got;
  logic                 gap_done, poll_last, poll_clr, poll_bump;
  logic                 stat_got, poll_ok, op_frame_end;
  logic [7:0]           addr_byte, opc_byte;

  // ---------------- helpers ----------------
  nvs_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .run(state_q == S_GAP), .expired(gap_done)
  );

  nvs_poll_limit #(.MAX_POLLS(MAX_POLLS)) u_poll (
    .clk(clk), .rst_n(rst_n), .clear(poll_clr), .bump(poll_bump), .last(poll_last)
  );

  nvs_page_chunk #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) u_chunk (
    .addr_lo(addr_q[PAGE_W-1:0]), .remaining(rem_q), .chunk(chunk)
  );

  // ---------------- byte interface ----------------
  assign in_frame = (state_q == S_WREN) || (state_q == S_RDSR) || (state_q == S_STAT) ||
                    (state_q == S_OPC)  || (state_q == S_ADDR) || (state_q == S_DATA);

  assign spi_cs_n       = !in_frame;
  assign byte_req_valid = in_frame && !wait_q && ((state_q != S_DATA) || wdata_valid);
  assign req_fire       = byte_req_valid && byte_req_ready;
  assign got            = wait_q && byte_rsp_valid;
  assign wdata_ready    = (state_q == S_DATA) && !wait_q && byte_req_ready;

  always_comb begin
    case (abyte_q)
      2'd0:    addr_byte = addr_q[23:16];
      2'd1:    addr_byte = addr_q[15:8];
      default: addr_byte = addr_q[7:0];
    endcase
    case (op_q)
      OP_SECTOR: opc_byte = OPC_SECTOR;
      OP_BULK:   opc_byte = OPC_BULK;
      default:   opc_byte = OPC_PROG;
    endcase
    case (state_q)
      S_WREN:  byte_req_tx = OPC_WREN;
      S_RDSR:  byte_req_tx = OPC_RDSR;
      S_STAT:  byte_req_tx = 8'h00;
      S_OPC:   byte_req_tx = opc_byte;
      S_ADDR:  byte_req_tx = addr_byte;
      S_DATA:  byte_req_tx = wdata;
      default: byte_req_tx = 8'h00;
    endcase
  end

  // ---------------- poll evaluation ----------------
  assign stat_got  = (state_q == S_STAT) && got;
  assign poll_ok   = post_q ? !byte_rsp_rx[WIP_BIT]
                            : (!byte_rsp_rx[WIP_BIT] && byte_rsp_rx[WEL_BIT]);
  assign poll_bump = stat_got && !poll_ok;

  assign op_frame_end = got && (
      ((state_q == S_OPC)  && (op_q == OP_BULK)) ||
      ((state_q == S_ADDR) && (abyte_q == 2'd2) && (op_q == OP_SECTOR)) ||
      ((state_q == S_DATA) && (left_q == LEN_W'(1))));

  assign poll_clr  = ((state_q == S_WREN) && got) || op_frame_end;
  assign rem_after = rem_q - chunk;

  // ---------------- one outstanding byte ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wait_q <= 1'b0;
    else if (req_fire) wait_q <= 1'b1;
    else if (got)      wait_q <= 1'b0;
  end

  // ---------------- operation sequence ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      resume_q <= S_IDLE;
      op_q     <= OP_NONE;
      addr_q   <= '0;
      rem_q    <= '0;
      left_q   <= '0;
      abyte_q  <= '0;
      post_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (cmd_valid) begin
          op_q   <= nvs_op_e'(cmd_op);
          addr_q <= cmd_addr;
          rem_q  <= cmd_len;
          err_q  <= 1'b0;
          if ((nvs_op_e'(cmd_op) == OP_NONE) ||
              ((nvs_op_e'(cmd_op) == OP_PROG) && (cmd_len == '0))) begin
            state_q <= S_FIN;
          end else begin
            state_q  <= S_GAP;
            resume_q <= S_WREN;
          end
        end

        S_GAP: if (gap_done) state_q <= resume_q;

        S_WREN: if (got) begin
          state_q  <= S_GAP;
          resume_q <= S_RDSR;
          post_q   <= 1'b0;
        end

        S_RDSR: if (got) state_q <= S_STAT;

        S_STAT: if (got) begin
          if (poll_ok) begin
            if (!post_q) begin
              state_q  <= S_GAP;
              resume_q <= S_OPC;
              left_q   <= chunk;
              abyte_q  <= '0;
            end else if ((op_q == OP_PROG) && (rem_after != '0)) begin
              addr_q   <= addr_q + ADDR_W'(chunk);
              rem_q    <= rem_after;
              state_q  <= S_GAP;
              resume_q <= S_WREN;
            end else begin
              state_q  <= S_FIN;
            end
          end else if (poll_last) begin
            err_q   <= 1'b1;
            state_q <= S_FIN;
          end else begin
            state_q  <= S_GAP;
            resume_q <= S_RDSR;
          end
        end

        S_OPC: if (got) begin
          if (op_q == OP_BULK) begin
            state_q  <= S_GAP;
            resume_q <= S_RDSR;
            post_q   <= 1'b1;
          end else begin
            state_q <= S_ADDR;
          end
        end

        S_ADDR: if (got) begin
          if (abyte_q != 2'd2) begin
            abyte_q <= abyte_q + 2'd1;
          end else if (op_q == OP_SECTOR) begin
            state_q  <= S_GAP;
            resume_q <= S_RDSR;
            post_q   <= 1'b1;
          end else begin
            state_q <= S_DATA;
          end
        end

        S_DATA: if (got) begin
          left_q <= left_q - LEN_W'(1);
          if (left_q == LEN_W'(1)) begin
            state_q  <= S_GAP;
            resume_q <= S_RDSR;
            post_q   <= 1'b1;
          end
        end

        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state_q == S_IDLE);
  assign done      = (state_q == S_FIN);
  assign err       = err_q;
endmodule

// File: rtl/nvs_flash_writer_chk.sv
module nvs_flash_writer_chk #(
  parameter int GAP_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       wdata_valid,
  input logic       wdata_ready,
  input logic       spi_cs_n,
  input logic       byte_req_valid,
  input logic       byte_req_ready,
  input logic [7:0] byte_req_tx,
  input logic       done,
  input logic       err
);
  localparam int HW = $clog2(GAP_CYCLES + 1) + 1;
  logic [HW-1:0] hi_cnt;
  logic          cs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      cs_prev <= 1'b1;
    end else begin
      cs_prev <= spi_cs_n;
      if (!spi_cs_n)                       hi_cnt <= '0;
      else if (hi_cnt < HW'(GAP_CYCLES))   hi_cnt <= hi_cnt + 1'b1;
    end
  end

  a_r3_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_prev && !spi_cs_n) |-> (hi_cnt >= HW'(GAP_CYCLES)));

  a_r3_req_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req_valid |-> !spi_cs_n);

  a_r12_stream_with_engine: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata_valid && wdata_ready) |-> (byte_req_valid && byte_req_ready && !spi_cs_n));

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req_valid && !byte_req_ready) |=> (byte_req_valid && $stable(byte_req_tx)));

  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r13_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (done && spi_cs_n));
endmodule

bind nvs_flash_writer nvs_flash_writer_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .spi_cs_n(spi_cs_n),
  .byte_req_valid(byte_req_valid), .byte_req_ready(byte_req_ready),
  .byte_req_tx(byte_req_tx), .done(done), .err(err)
);

// File: tb/nvs_flash_writer_bench.sv
`timescale 1ns/1ps
module nvs_flash_writer_bench;
  localparam int GAP  = 3;
  localparam int MAXP = 6;
  localparam int LW   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_ready;
  logic [1:0]    cmd_op = '0;
  logic [23:0]   cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic          wdata_valid, wdata_ready;
  logic [7:0]    wdata;
  logic          spi_cs_n, byte_req_valid, byte_req_tx_dummy;
  logic [7:0]    byte_req_tx;
  logic          eng_rdy, rsp_v;
  logic [7:0]    rsp_d;
  logic          done, err;

  nvs_flash_writer #(.GAP_CYCLES(GAP), .MAX_POLLS(MAXP), .PAGE_BYTES(256), .LEN_W(LW))
  u_nvs_flash_writer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
    .spi_cs_n(spi_cs_n), .byte_req_valid(byte_req_valid), .byte_req_ready(eng_rdy),
    .byte_req_tx(byte_req_tx), .byte_rsp_valid(rsp_v), .byte_rsp_rx(rsp_d),
    .done(done), .err(err)
  );
  assign byte_req_tx_dummy = 1'b0;

  int checks = 0, errors = 0;

  // ---------------- write stream source ----------------
  int   src_cnt, src_total = 0;
  logic src_clr = 1'b0;
  function automatic logic [7:0] pat(int k);
    return 8'((k * 13 + 5) & 255);
  endfunction
  assign wdata_valid = src_cnt < src_total;
  assign wdata       = pat(src_cnt);
  always @(posedge clk) begin
    if (!rst_n || src_clr)            src_cnt <= 0;
    else if (wdata_valid && wdata_ready) src_cnt <= src_cnt + 1;
  end

  // ---------------- flash responder model ----------------
  int   busy_cfg = 0, wel_delay_cfg = 0;
  logic stall = 1'b0;
  int   wip_left, wel_wait, idx, hi_run, gap_viol, commit_viol, nlog, ndat;
  logic wel, wel_arm, cs_prev;
  logic [7:0]  cur_op, cur_b1;
  logic [23:0] cur_addr;
  logic [7:0]  log_op [0:127];
  logic [7:0]  log_b1 [0:127];
  int          log_len [0:127];
  logic [23:0] log_addr [0:127];
  logic [7:0]  dat_log [0:1023];

  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_v <= 1'b0; rsp_d <= 8'h00; eng_rdy <= 1'b1;
      wip_left <= 0; wel_wait <= 0; idx <= 0; hi_run <= 0;
      gap_viol <= 0; commit_viol <= 0; nlog <= 0; ndat <= 0;
      wel <= 1'b0; wel_arm <= 1'b0; cs_prev <= 1'b1;
      cur_op <= 8'h00; cur_b1 <= 8'h00; cur_addr <= '0;
    end else begin
      rsp_v   <= 1'b0;
      cs_prev <= spi_cs_n;
      eng_rdy <= stall ? ~eng_rdy : 1'b1;
      if (spi_cs_n) hi_run <= hi_run + 1;
      if (cs_prev && !spi_cs_n) begin
        if (hi_run < GAP) gap_viol <= gap_viol + 1;
        hi_run <= 0;
      end
      if (spi_cs_n && !cs_prev) begin
        if (nlog < 128) begin
          log_op[nlog] <= cur_op; log_b1[nlog] <= cur_b1;
          log_len[nlog] <= idx;   log_addr[nlog] <= cur_addr;
        end
        nlog <= nlog + 1;
        idx  <= 0;
        if (cur_op == 8'h06) begin
          wel_arm <= 1'b1; wel_wait <= wel_delay_cfg; wel <= (wel_delay_cfg == 0);
        end else if (cur_op == 8'hD8 || cur_op == 8'hC7 || cur_op == 8'h02) begin
          wip_left <= busy_cfg; wel <= 1'b0; wel_arm <= 1'b0;
        end
      end
      if (!spi_cs_n && byte_req_valid && eng_rdy) begin
        rsp_v <= 1'b1;
        rsp_d <= 8'hA5;
        idx   <= idx + 1;
        if (idx == 0) begin
          cur_op <= byte_req_tx;
          if ((byte_req_tx == 8'hD8 || byte_req_tx == 8'hC7 || byte_req_tx == 8'h02) && !wel)
            commit_viol <= commit_viol + 1;
        end
        if (idx == 1) cur_b1 <= byte_req_tx;
        if (idx >= 1 && idx <= 3) cur_addr <= {cur_addr[15:0], byte_req_tx};
        if (idx >= 4 && cur_op == 8'h02) begin
          if (ndat < 1024) dat_log[ndat] <= byte_req_tx;
          ndat <= ndat + 1;
        end
        if (idx == 1 && cur_op == 8'h05) begin
          rsp_d <= {6'b0, wel, (wip_left > 0)};
          if (wip_left > 0) wip_left <= wip_left - 1;
          if (wel_arm && !wel) begin
            if (wel_wait <= 1) wel <= 1'b1;
            wel_wait <= wel_wait - 1;
          end
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  logic [7:0]  exp_op [0:127];
  int          exp_len [0:127];
  logic [23:0] exp_addr [0:127];
  int          nexp;

  task automatic push(input logic [7:0] op, input int len, input logic [23:0] a);
    exp_op[nexp] = op; exp_len[nexp] = len; exp_addr[nexp] = a; nexp++;
  endtask

  task automatic push_polls(input int n);
    for (int i = 0; i < n; i++) push(8'h05, 2, 24'h0);
  endtask

  task automatic compare_frames(input int base, input string req);
    check(nlog - base == nexp, req, "frame count", nlog - base, nexp);
    for (int i = 0; i < nexp && base + i < nlog; i++) begin
      check(log_op[base+i] == exp_op[i], req, "frame opcode", log_op[base+i], exp_op[i]);
      check(log_len[base+i] == exp_len[i], req, "frame length", log_len[base+i], exp_len[i]);
      if (exp_op[i] == 8'hD8 || exp_op[i] == 8'h02)
        check(log_addr[base+i] == exp_addr[i], req, "frame address",
              log_addr[base+i], exp_addr[i]);
      if (exp_op[i] == 8'h05)
        check(log_b1[base+i] == 8'h00, "R4", "poll filler byte", log_b1[base+i], 0);
    end
  endtask

  bit last_err;
  task automatic run_cmd(input logic [1:0] op, input logic [23:0] a, input int len);
    int k;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_len = LW'(len);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R13", "ready after accept", cmd_ready, 0);
    check(err == 1'b0 || done, "R10", "err cleared on accept", err, 0);
    k = 0;
    while (!done && k < 20000) begin @(negedge clk); k++; end
    check(done == 1'b1, "R13", "done seen", done, 1);
    check(spi_cs_n == 1'b1, "R10", "cs high at done", spi_cs_n, 1);
    last_err = err;
    @(negedge clk);
    check(done == 1'b0, "R13", "done one cycle", done, 0);
  endtask

  task automatic set_src(input int total);
    @(negedge clk); src_clr = 1'b1; src_total = total;
    @(negedge clk); src_clr = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    check(spi_cs_n == 1'b1, "R1", "cs_n", spi_cs_n, 1);
    check(byte_req_valid == 1'b0, "R1", "req_valid", byte_req_valid, 0);
    check(done == 1'b0, "R1", "done", done, 0);
    check(err == 1'b0, "R1", "err", err, 0);
    check(cmd_ready == 1'b1, "R1", "cmd_ready", cmd_ready, 1);
  endtask

  task automatic t_sector;  // R2 R4 R5 R6 R9
    int base;
    busy_cfg = 3; wel_delay_cfg = 2; base = nlog; nexp = 0;
    push(8'h06, 1, 0); push_polls(3); push(8'hD8, 4, 24'h123456); push_polls(4);
    run_cmd(2'd0, 24'h123456, 0);
    check(last_err == 1'b0, "R5", "no error", last_err, 0);
    compare_frames(base, "R6");
  endtask

  task automatic t_bulk;  // R6 R9
    int base;
    busy_cfg = 0; wel_delay_cfg = 0; base = nlog; nexp = 0;
    push(8'h06, 1, 0); push_polls(1); push(8'hC7, 1, 0); push_polls(1);
    run_cmd(2'd1, 24'hABCDEF, 0);
    compare_frames(base, "R6");
  endtask

  task automatic t_program(input logic [23:0] a, input int len, input int busy,
                           input bit stl);
    int base, dbase, rem, c;
    logic [23:0] pa;
    busy_cfg = busy; wel_delay_cfg = 0; stall = stl;
    set_src(len + 5);
    base = nlog; dbase = ndat; nexp = 0; rem = len; pa = a;
    while (rem > 0) begin
      c = 256 - int'(pa[7:0]);
      if (rem < c) c = rem;
      push(8'h06, 1, 0); push_polls(1); push(8'h02, 4 + c, pa); push_polls(busy + 1);
      rem -= c; pa = pa + 24'(c);
    end
    run_cmd(2'd2, a, len);
    stall = 1'b0;
    compare_frames(base, "R8");
    check(src_cnt == len, "R12", "stream bytes taken", src_cnt, len);
    check(ndat - dbase == len, "R7", "data bytes sent", ndat - dbase, len);
    for (int i = 0; i < len; i++)
      if (dat_log[dbase+i] != pat(i))
        check(1'b0, "R7", "data byte order", dat_log[dbase+i], pat(i));
  endtask

  task automatic t_empty;  // R11
    int base;
    base = nlog;
    run_cmd(2'd2, 24'h000100, 0);
    repeat (8) @(negedge clk);
    check(nlog == base, "R11", "zero-length frames", nlog - base, 0);
    run_cmd(2'd3, 24'h000100, 9);
    repeat (8) @(negedge clk);
    check(nlog == base, "R11", "no-op frames", nlog - base, 0);
  endtask

  task automatic t_timeout;  // R10
    int base;
    busy_cfg = 10; wel_delay_cfg = 0; base = nlog; nexp = 0;
    push(8'h06, 1, 0); push_polls(1); push(8'hD8, 4, 24'h010000); push_polls(MAXP);
    run_cmd(2'd0, 24'h010000, 0);
    check(last_err == 1'b1, "R10", "err after cap", last_err, 1);
    check(err == 1'b1, "R10", "err held", err, 1);
    compare_frames(base, "R10");
  endtask

  task automatic t_recover;  // R10 R5
    int base;
    busy_cfg = 1; base = nlog; nexp = 0;
    push(8'h06, 1, 0); push_polls(5); push(8'hC7, 1, 0); push_polls(2);
    run_cmd(2'd1, 24'h0, 0);
    check(last_err == 1'b0, "R10", "err after recovery", last_err, 0);
    compare_frames(base, "R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_sector();
    t_bulk();
    t_program(24'h0001F0, 300, 1, 1'b0);
    t_program(24'h000500, 5, 0, 1'b1);
    t_empty();
    t_timeout();
    t_recover();
    check(gap_viol == 0, "R3", "short cs high gaps", gap_viol, 0);
    check(commit_viol == 0, "R5", "commit before latch", commit_viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule